// File: doc/BRIEF.md
# Subarray Precharge Gating Controller

This block decides, cycle by cycle, which subarrays of a banked cache data array have their bitlines precharged. Every subarray owns an idle-cycle counter that climbs by one each clock while the subarray goes unused and drops to zero when it is accessed. A subarray is kept precharged while its counter is not above a programmable threshold, and is gated off once the counter passes it. Recently touched subarrays therefore stay ready, and the ones that have gone quiet stop precharging and stop leaking through their bitlines.

An access arrives as a valid strobe with a subarray index. If the target is already precharged, the access is taken at once and the ready output stays high. If the target is gated, ready falls for exactly one cycle. In that cycle the target's precharge is forced on, and the access finishes at the end of it. Counters saturate rather than wrap, and after reset every counter holds its saturated value. As a result every subarray starts out gated, and the first touch of each one pays the extra cycle.

Top module: `pg_precharge_gate`

## Requirements
- R1: After reset every bit of `pc_en` is 0 (each idle counter holds its all-ones value of 1023, which is above any threshold below 1023), and `acc_rdy` is 1.
- R2: Each idle counter grows by one per clock and stops at its all-ones value of 1023 without wrapping. With `thr` = 1022, an untouched subarray stays gated for any number of cycles.
- R3: Bit i of `pc_en` is 1 when counter i is less than or equal to `thr` and 0 when it is greater. Equality counts as active.
- R4: An access (`acc_vld`=1 while `acc_rdy`=1) to a subarray whose `pc_en` bit is 1 is taken in that cycle, `acc_rdy` stays 1 in the next cycle, and that subarray's counter is 0 in the next cycle.
- R5: An access to a subarray whose `pc_en` bit is 0 makes `acc_rdy` 0 for exactly the next cycle. In that cycle the target's `pc_en` bit is 1 and its counter keeps its old value. The counter is 0 in the cycle after.
- R6: While `acc_rdy` is 0, `acc_vld` and `acc_idx` have no effect on any counter.
- R7: `thr` is combinational into the compare, so a change of `thr` changes `pc_en` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_vld | input | 1 | Access request strobe |
| acc_idx | input | IDX_W (5) | Target subarray of the request |
| thr | input | CNT_W (10) | Idle-cycle threshold |
| pc_en | output | NUM_SUB (32) | Precharge enable, one bit per subarray |
| acc_rdy | output | 1 | High when a request can be taken this cycle |

## Verification
The properties assume that `acc_idx` names an existing subarray whenever `acc_vld` is high, and that `thr` is steady across the cycle in which a gated access is taken and the wake cycle that follows. The stimulus draws indices only from the legal range, mostly from a small hot set, so that both gated and active hits occur. It changes `thr` only between blocks of cycles and never while a wake cycle is pending. During wake cycles it keeps `acc_vld` high with unrelated indices, so the ignore rule is tested under pressure.

// File: rtl/pg_pkg.sv
// Package pg_pkg
// Shared definitions for the precharge gating controller.
// Assumes: nothing beyond IEEE 1800-2017.
package pg_pkg;

    // Access sequencer state: idle/accepting, or waking a gated subarray.
    typedef enum logic {
        SEQ_OPEN = 1'b0,
        SEQ_WAKE = 1'b1
    } seq_state_e;

    // Index width for a given subarray count (at least one bit).
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/pg_decay_bank.sv
// Module pg_decay_bank
// One saturating idle counter per subarray. A counter is cleared by its
// clear bit, frozen by its hold bit, and otherwise moves up by one until it
// reaches all-ones. Reset loads all-ones so each subarray starts gated.
// Assumes: clr_vec and hold_vec are never both set for the same subarray.
module pg_decay_bank #(
    parameter int NUM_SUB = 32,
    parameter int CNT_W   = 10
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_SUB-1:0]             clr_vec,
    input  logic [NUM_SUB-1:0]             hold_vec,
    output logic [NUM_SUB-1:0][CNT_W-1:0]  cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    for (genvar g = 0; g < NUM_SUB; g++) begin : g_cnt
        logic [CNT_W-1:0] cnt_q;
        logic [CNT_W-1:0] cnt_d;

        // Next value: clear, hold, saturate or count.
        always_comb begin
            if (clr_vec[g])
                cnt_d = '0;
            else if (hold_vec[g] || (cnt_q == CNT_MAX))
                cnt_d = cnt_q;
            else
                cnt_d = cnt_q + 1'b1;
        end

        // Counter register, reset to the saturated value.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt_q <= CNT_MAX;
            else
                cnt_q <= cnt_d;
        end

        assign cnt[g] = cnt_q;
    end

endmodule

// File: rtl/pg_thresh_cmp.sv
// Module pg_thresh_cmp
// Compares every idle counter against the shared threshold. A subarray is
// live (should precharge) when its counter is at or below the threshold.
// Assumes: thr is a plain level, sampled combinationally.
module pg_thresh_cmp #(
    parameter int NUM_SUB = 32,
    parameter int CNT_W   = 10
) (
    input  logic [NUM_SUB-1:0][CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0]              thr,
    output logic [NUM_SUB-1:0]            live_vec
);
    for (genvar g = 0; g < NUM_SUB; g++) begin : g_cmp
        // Equality is treated as still active.
        assign live_vec[g] = (cnt[g] <= thr);
    end

endmodule

// File: rtl/pg_access_seq.sv
// Module pg_access_seq
// Takes access requests. A request to a live subarray clears its counter
// at once. A request to a gated subarray costs a wake cycle: ready drops,
// the target's precharge is forced on and its counter is frozen, then the
// counter is cleared at the end of the wake cycle.
// Assumes: acc_idx < NUM_SUB whenever acc_vld is high.
module pg_access_seq
    import pg_pkg::*;
#(
    parameter int NUM_SUB = 32,
    parameter int IDX_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_vld,
    input  logic [IDX_W-1:0]   acc_idx,
    input  logic [NUM_SUB-1:0] live_vec,
    output logic               acc_rdy,
    output logic [NUM_SUB-1:0] clr_vec,
    output logic [NUM_SUB-1:0] hold_vec,
    output logic [NUM_SUB-1:0] force_vec
);
    seq_state_e         state_q;
    logic [IDX_W-1:0]   tgt_q;
    logic [NUM_SUB-1:0] req_sel;
    logic [NUM_SUB-1:0] tgt_sel;
    logic               take;
    logic               tgt_live;

    // One-hot decode of the request index and the stored wake target.
    always_comb begin
        for (int i = 0; i < NUM_SUB; i++) begin
            req_sel[i] = (acc_idx == IDX_W'(i));
            tgt_sel[i] = (tgt_q == IDX_W'(i));
        end
    end

    // A request is taken only while the sequencer is open.
    assign take     = acc_vld && (state_q == SEQ_OPEN);
    assign tgt_live = |(req_sel & live_vec);
    assign acc_rdy  = (state_q == SEQ_OPEN);

    // Per-subarray clear, hold and force controls.
    always_comb begin
        for (int i = 0; i < NUM_SUB; i++) begin
            force_vec[i] = (state_q == SEQ_WAKE) && tgt_sel[i];
            clr_vec[i]   = (take && tgt_live && req_sel[i]) || force_vec[i];
            hold_vec[i]  = take && !tgt_live && req_sel[i];
        end
    end

    // Sequencer state and wake target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_OPEN;
            tgt_q   <= '0;
        end else if (take && !tgt_live) begin
            state_q <= SEQ_WAKE;
            tgt_q   <= acc_idx;
        end else begin
            state_q <= SEQ_OPEN;
        end
    end

endmodule

// File: rtl/pg_precharge_gate.sv
// Module pg_precharge_gate
// Top level: idle counters, threshold compare and access sequencer. The
// precharge enable is the compare result, plus the forced wake of a gated
// target.
// Assumes: acc_idx is in range while acc_vld is high.
module pg_precharge_gate #(
    parameter int NUM_SUB = 32,
    parameter int CNT_W   = 10,
    parameter int IDX_W   = pg_pkg::idx_width(NUM_SUB)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_vld,
    input  logic [IDX_W-1:0]   acc_idx,
    input  logic [CNT_W-1:0]   thr,
    output logic [NUM_SUB-1:0] pc_en,
    output logic               acc_rdy
);
    logic [NUM_SUB-1:0][CNT_W-1:0] cnt;
    logic [NUM_SUB-1:0]            live_vec;
    logic [NUM_SUB-1:0]            clr_vec;
    logic [NUM_SUB-1:0]            hold_vec;
    logic [NUM_SUB-1:0]            force_vec;

    pg_decay_bank #(.NUM_SUB(NUM_SUB), .CNT_W(CNT_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_vec  (clr_vec),
        .hold_vec (hold_vec),
        .cnt      (cnt)
    );

    pg_thresh_cmp #(.NUM_SUB(NUM_SUB), .CNT_W(CNT_W)) u_cmp (
        .cnt      (cnt),
        .thr      (thr),
        .live_vec (live_vec)
    );

    pg_access_seq #(.NUM_SUB(NUM_SUB), .IDX_W(IDX_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_vld   (acc_vld),
        .acc_idx   (acc_idx),
        .live_vec  (live_vec),
        .acc_rdy   (acc_rdy),
        .clr_vec   (clr_vec),
        .hold_vec  (hold_vec),
        .force_vec (force_vec)
    );

    // Precharge where live, or where a wake cycle forces it.
    assign pc_en = live_vec | force_vec;

endmodule

// File: rtl/pg_precharge_gate_chk.sv
// Module pg_precharge_gate_chk
// Temporal properties on the top-level ports of pg_precharge_gate.
// Assumes: acc_idx in range when acc_vld is high; thr steady across a wake.
module pg_precharge_gate_chk #(
    parameter int NUM_SUB = 32,
    parameter int CNT_W   = 10,
    parameter int IDX_W   = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               acc_vld,
    input logic [IDX_W-1:0]   acc_idx,
    input logic [CNT_W-1:0]   thr,
    input logic [NUM_SUB-1:0] pc_en,
    input logic               acc_rdy
);
    // Request indices must name an existing subarray.
    assert_idx_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_vld |-> (int'(acc_idx) < NUM_SUB));

    // A gated target drops ready for the next cycle.
    assert_gated_stalls_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && acc_rdy && !pc_en[acc_idx]) |=> !acc_rdy);

    // The wake lasts exactly one cycle.
    assert_wake_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_rdy |=> acc_rdy);

    // During the wake the target subarray is precharged.
    assert_wake_forces_pc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && acc_rdy && !pc_en[acc_idx]) |=> pc_en[$past(acc_idx)]);

    // A live target is taken without a stall and stays precharged.
    assert_live_no_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && acc_rdy && pc_en[acc_idx]) |=> (acc_rdy && pc_en[$past(acc_idx)]));

    // After the wake the touched subarray is live (counter at zero).
    assert_after_wake_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_rdy && $stable(thr)) |=> pc_en[$past(acc_idx, 2)]);

endmodule

bind pg_precharge_gate pg_precharge_gate_chk #(
    .NUM_SUB(NUM_SUB), .CNT_W(CNT_W), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_idx(acc_idx),
    .thr(thr), .pc_en(pc_en), .acc_rdy(acc_rdy)
);

// File: tb/test_pg_precharge_gate.sv
// Bench for pg_precharge_gate: directed corners plus seeded random traffic,
// checked each cycle against a behavioural model held in bench arrays.
module test_pg_precharge_gate;
    localparam int NS     = 32;
    localparam int CW     = 10;
    localparam int IW     = 5;
    localparam int CMAX   = (1 << CW) - 1;
    localparam int PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_vld = 1'b0;
    logic [IW-1:0] acc_idx = '0;
    logic [CW-1:0] thr = 10'd100;
    logic [NS-1:0] pc_en;
    logic          acc_rdy;

    int m_cnt [NS];
    bit m_wake;
    int m_tgt;
    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    always #(PERIOD/2) clk = ~clk;

    pg_precharge_gate #(.NUM_SUB(NS), .CNT_W(CW)) i_pg_precharge_gate (
        .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_idx(acc_idx),
        .thr(thr), .pc_en(pc_en), .acc_rdy(acc_rdy)
    );

    function automatic logic [NS-1:0] exp_pc();
        logic [NS-1:0] v;
        for (int i = 0; i < NS; i++)
            v[i] = (m_cnt[i] <= int'(thr)) || (m_wake && m_tgt == i);
        return v;
    endfunction

    task automatic check(input string tag);
        logic [NS-1:0] e;
        e = exp_pc();
        n_vec++;
        if (pc_en !== e || acc_rdy !== !m_wake) begin
            n_bad++;
            $display("FAIL %s: pc_en=%h rdy=%b expected pc_en=%h rdy=%b",
                     tag, pc_en, acc_rdy, e, !m_wake);
        end
    endtask

    // One cycle: drive at negedge, check, advance model at the edge.
    task automatic step(input bit v, input int idx, input string tag);
        int  nxt [NS];
        bit  take, live, nwake;
        acc_vld = v;
        acc_idx = IW'(idx);
        #1;
        check(tag);
        take  = v && !m_wake;
        live  = (m_cnt[idx] <= int'(thr));
        nwake = take && !live;
        for (int j = 0; j < NS; j++) begin
            if (m_wake && j == m_tgt)        nxt[j] = 0;
            else if (take && j == idx)       nxt[j] = live ? 0 : m_cnt[j];
            else if (m_cnt[j] < CMAX)        nxt[j] = m_cnt[j] + 1;
            else                             nxt[j] = m_cnt[j];
        end
        @(posedge clk);
        for (int j = 0; j < NS; j++) m_cnt[j] = nxt[j];
        if (nwake) m_tgt = idx;
        m_wake = nwake;
        @(negedge clk);
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(1234);
        for (int i = 0; i < NS; i++) m_cnt[i] = CMAX;
        m_wake = 0; m_tgt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, all gated and ready.
        step(0, 0, "R1 reset");
        // R5: first touch of subarray 3 wakes it for one cycle.
        step(1, 3, "R5 gated access");
        // R6: requests during the wake are ignored.
        step(1, 9, "R6 wake ignores request");
        step(0, 0, "R5 after wake");
        // R4: now live, immediate access keeps ready high.
        step(1, 3, "R4 live access");
        // R3: small threshold, watch equality then gating.
        thr = 10'd4;
        for (int k = 0; k < 8; k++) step(0, 0, "R3 threshold edge");
        // R7: raising thr re-enables in the same cycle.
        thr = 10'd200;
        step(0, 0, "R7 thr change");
        thr = 10'd4;
        step(0, 0, "R7 thr lower");
        // R2: saturation, long idle with thr just below max.
        thr = 10'(CMAX - 1);
        for (int k = 0; k < 1100; k++) step(0, 0, "R2 saturate");
        // Random traffic over several thresholds.
        for (int b = 0; b < 12; b++) begin
            while (m_wake) step(0, 0, "R5 drain");
            case ($urandom % 4)
                0: thr = 10'd0;
                1: thr = 10'd3;
                2: thr = 10'd20;
                default: thr = 10'($urandom % 120);
            endcase
            for (int k = 0; k < 300; k++) begin
                int ix;
                ix = ($urandom % 4 == 0) ? int'($urandom % NS) : int'($urandom % 4);
                step(($urandom % 3) != 0, ix, "R3 R4 R5 R6 random");
            end
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule